// File: doc/BRIEF.md
# Trim-Calibrated Temperature Code Converter

This block maps temperatures in degrees Celsius to the raw code a thermal sensor produces, and maps raw codes back to degrees. The mapping is calibrated by two factory trim values taken from a 32-bit trim word. A pulse on the load strobe captures that word. Values that are zero or out of range are replaced by defaults set through parameters. Bit 23 of the word selects the calibration. One-point calibration shifts the code by a single offset. Two-point calibration interpolates linearly between the anchors at 25 °C and 85 °C.

Each direction has its own request channel with a valid/ready handshake. Both channels share one signed result bus and one error flag, and each has its own one-cycle done pulse. Every accepted conversion passes through a bit-serial restoring divider. One-point conversions divide by one, so all requests take the same number of cycles. Requests that cannot produce a number end at once with the error flag set: a sensor code outside the plausible band, or a two-point reverse conversion whose trims are equal.

Top module: `trim_temp_codec`

## Requirements
- R1: After reset both ready outputs are high, both done outputs are low, `sensor_id` is 0, one-point mode is active, and the trims hold their defaults: trim1 = DEF_FUSE[7:0] (55) and trim2 = DEF_FUSE[15:8] (0).
- R2: On `trim_load`, trim1 takes `trim_word[7:0]`. If that byte is 0, below TRIM_MIN (40) or above TRIM_MAX (100), trim1 takes DEF_FUSE[7:0] instead.
- R3: On `trim_load`, trim2 takes `trim_word[15:8]`. If that byte is 0, trim2 takes DEF_FUSE[15:8] instead.
- R4: On `trim_load`, `trim_word[23]` selects the mode (0 for one-point, 1 for two-point), and `sensor_id` takes `trim_word[19:16]`.
- R5: In one-point mode, a temperature request returns temp + trim1 − 25.
- R6: In one-point mode, a code request returns code − trim1 + 25.
- R7: In two-point mode, a temperature request returns (temp − 25)·(trim2 − trim1)/60 + trim1, and a code request returns (code − trim1)·60/(trim2 − trim1) + 25. Each quotient is truncated toward zero.
- R8: A code request whose code is below 75 or above 175 ends with `c2t_done` and `err` both high.
- R9: A two-point code request with trim2 equal to trim1 ends with `err` high. A two-point temperature request under the same trims completes normally with `err` low.
- R10: A request is accepted only when valid and ready are both high. Both readies stay low while a conversion runs. The matching done output is high for exactly one cycle, at most NW+2 (18) cycles after acceptance, with `result` and `err` valid in that cycle.
- R11: When both channels request in the same cycle, the temperature request is served first. The code request is held off and completes afterwards.
- R12: A conversion uses the trims and mode that were in force when it was accepted. A trim load in the cycle of acceptance, or during the conversion, affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trim_load | input | 1 | Capture `trim_word` this cycle |
| trim_word | input | 32 | Factory trim word |
| t2c_valid | input | 1 | Temperature-to-code request |
| t2c_temp | input | 8 | Temperature in °C, unsigned |
| t2c_ready | output | 1 | Temperature channel can accept |
| t2c_done | output | 1 | Temperature-to-code result pulse |
| c2t_valid | input | 1 | Code-to-temperature request |
| c2t_code | input | 8 | Raw sensor code |
| c2t_ready | output | 1 | Code channel can accept |
| c2t_done | output | 1 | Code-to-temperature result pulse |
| result | output | 18 | Signed conversion result |
| err | output | 1 | Error flag: no data, or zero divisor |
| sensor_id | output | 4 | Sensor identifier from the trim word |

## Verification
Two events can fall in the same cycle. Both channels can raise valid together, and a trim load can coincide with a request being accepted. The bench drives both valids on one edge and checks three things: the temperature result arrives first, code ready stays low until that result appears, and the code result then matches the model. It also pulses `trim_load` in the same cycle as an acceptance. The returned value must match the old trims, and the next request must match the new ones.

// File: rtl/trim_temp_codec.sv
module trim_temp_codec #(
  parameter int TW = 8,
  parameter logic [2*TW-1:0] DEF_FUSE = 16'd55,
  parameter int TRIM_MIN = 40,
  parameter int TRIM_MAX = 100,
  parameter int NODATA_LO = 75,
  parameter int NODATA_HI = 175
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trim_load,
  input  logic [31:0]            trim_word,
  input  logic                   t2c_valid,
  input  logic [TW-1:0]          t2c_temp,
  output logic                   t2c_ready,
  output logic                   t2c_done,
  input  logic                   c2t_valid,
  input  logic [TW-1:0]          c2t_code,
  output logic                   c2t_ready,
  output logic                   c2t_done,
  output logic signed [2*TW+1:0] result,
  output logic                   err,
  output logic [3:0]             sensor_id
);
  localparam int NW = 2*TW;
  localparam int RW = NW+2;
  localparam int CW = $clog2(NW);
  localparam int MODE_BIT = 23;
  localparam int SID_LSB = 16;
  localparam logic signed [RW-1:0] K_LO = 25;
  localparam logic signed [RW-1:0] K_SPAN = 60;
  localparam logic signed [RW-1:0] K_ONE = 1;

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} st_t;
  st_t st;

  logic [TW-1:0] trim1_q, trim2_q, den_q, rem_q;
  logic          two_q, neg_q, ch_q;
  logic [NW-1:0] q_q;
  logic [CW-1:0] cnt_q;
  logic signed [RW-1:0] bias_q;

  assign t2c_ready = (st == S_IDLE);
  assign c2t_ready = (st == S_IDLE) && !t2c_valid;
  wire take_t2c = t2c_valid && t2c_ready;
  wire take_c2t = c2t_valid && c2t_ready;

  wire [TW-1:0] ld_t1 = trim_word[TW-1:0];
  wire [TW-1:0] ld_t2 = trim_word[2*TW-1:TW];
  wire t1_bad = (ld_t1 == '0) || (ld_t1 < TW'(TRIM_MIN)) || (ld_t1 > TW'(TRIM_MAX));

  wire signed [RW-1:0] s_t1  = $signed(RW'(trim1_q));
  wire signed [RW-1:0] s_t2  = $signed(RW'(trim2_q));
  wire signed [RW-1:0] s_tmp = $signed(RW'(t2c_temp));
  wire signed [RW-1:0] s_cod = $signed(RW'(c2t_code));
  wire signed [RW-1:0] dlt   = s_t2 - s_t1;

  logic signed [RW-1:0] n, d, b, na, da;
  always_comb begin
    if (take_t2c) begin
      n = two_q ? (s_tmp - K_LO) * dlt : s_tmp - K_LO;
      d = two_q ? K_SPAN : K_ONE;
      b = s_t1;
    end else begin
      n = two_q ? (s_cod - s_t1) * K_SPAN : s_cod - s_t1;
      d = two_q ? dlt : K_ONE;
      b = K_LO;
    end
    na = n[RW-1] ? -n : n;
    da = d[RW-1] ? -d : d;
  end

  wire nodata = take_c2t && ((c2t_code < TW'(NODATA_LO)) || (c2t_code > TW'(NODATA_HI)));
  wire bad = nodata || (d == '0);

  wire [TW:0] rem_sh = {rem_q, q_q[NW-1]};
  wire        ge     = rem_sh >= {1'b0, den_q};
  wire [TW:0] rem_nx = ge ? rem_sh - {1'b0, den_q} : rem_sh;
  wire signed [RW-1:0] qs  = $signed({2'b00, q_q});
  wire signed [RW-1:0] fin = neg_q ? bias_q - qs : bias_q + qs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      trim1_q <= DEF_FUSE[TW-1:0];
      trim2_q <= DEF_FUSE[2*TW-1:TW];
      two_q <= 1'b0;
      sensor_id <= '0;
      q_q <= '0; den_q <= '0; rem_q <= '0; cnt_q <= '0;
      neg_q <= 1'b0; ch_q <= 1'b0; bias_q <= '0;
      result <= '0; err <= 1'b0;
      t2c_done <= 1'b0; c2t_done <= 1'b0;
    end else begin
      t2c_done <= 1'b0;
      c2t_done <= 1'b0;
      if (trim_load) begin
        trim1_q <= t1_bad ? DEF_FUSE[TW-1:0] : ld_t1;
        trim2_q <= (ld_t2 == '0) ? DEF_FUSE[2*TW-1:TW] : ld_t2;
        two_q <= trim_word[MODE_BIT];
        sensor_id <= trim_word[SID_LSB+3:SID_LSB];
      end
      case (st)
        S_IDLE: if (take_t2c || take_c2t) begin
          ch_q <= take_c2t;
          if (bad) begin
            err <= 1'b1;
            t2c_done <= take_t2c;
            c2t_done <= take_c2t;
          end else begin
            q_q <= na[NW-1:0];
            den_q <= da[TW-1:0];
            rem_q <= '0;
            neg_q <= n[RW-1] ^ d[RW-1];
            bias_q <= b;
            cnt_q <= '0;
            st <= S_DIV;
          end
        end
        S_DIV: begin
          rem_q <= rem_nx[TW-1:0];
          q_q <= {q_q[NW-2:0], ge};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(NW-1)) st <= S_FIN;
        end
        default: begin
          result <= fin;
          err <= 1'b0;
          t2c_done <= !ch_q;
          c2t_done <= ch_q;
          st <= S_IDLE;
        end
      endcase
    end
  end

  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({t2c_done, c2t_done}));
  p_t2c_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    t2c_done |=> !t2c_done);
  p_c2t_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    c2t_done |=> !c2t_done);
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (t2c_valid && t2c_ready) |=> (!t2c_ready && !c2t_ready));
  p_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (t2c_valid && c2t_valid && t2c_ready) |=> !c2t_ready);
  p_nodata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (c2t_valid && c2t_ready && (c2t_code < TW'(NODATA_LO))) |=> (c2t_done && err));
  p_trim_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((trim1_q >= TW'(TRIM_MIN)) && (trim1_q <= TW'(TRIM_MAX))) || (trim1_q == DEF_FUSE[TW-1:0]));
  p_sid_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !trim_load |=> $stable(sensor_id));
endmodule

// File: tb/tb_trim_temp_codec.sv
module tb_trim_temp_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trim_load = 1'b0;
  logic [31:0] trim_word = '0;
  logic t2c_valid = 1'b0, c2t_valid = 1'b0;
  logic [7:0] t2c_temp = '0, c2t_code = '0;
  logic t2c_ready, t2c_done, c2t_ready, c2t_done, err;
  logic signed [17:0] result;
  logic [3:0] sensor_id;

  int checks = 0, errors = 0, cyc = 0;
  int m_t1 = 55, m_t2 = 0;
  bit m_two = 1'b0;

  always #10 clk = ~clk;

  trim_temp_codec dut (
    .clk(clk), .rst_n(rst_n), .trim_load(trim_load), .trim_word(trim_word),
    .t2c_valid(t2c_valid), .t2c_temp(t2c_temp), .t2c_ready(t2c_ready), .t2c_done(t2c_done),
    .c2t_valid(c2t_valid), .c2t_code(c2t_code), .c2t_ready(c2t_ready), .c2t_done(c2t_done),
    .result(result), .err(err), .sensor_id(sensor_id));

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit two, input int sid, input int t2, input int t1);
    logic [3:0] s = 4'(sid);
    logic [7:0] a = 8'(t2);
    logic [7:0] c = 8'(t1);
    return {8'h00, two, 3'b000, s, a, c};
  endfunction

  function automatic void apply(input logic [31:0] w);
    int a = int'(w[7:0]);
    m_t1 = (a == 0 || a < 40 || a > 100) ? 55 : a;
    m_t2 = (w[15:8] == 8'd0) ? 0 : int'(w[15:8]);
    m_two = w[23];
  endfunction

  function automatic void model(input bit ch, input int v, output bit e, output int r);
    e = 1'b0; r = 0;
    if (!ch) r = m_two ? (v - 25) * (m_t2 - m_t1) / 60 + m_t1 : v + m_t1 - 25;
    else if (v < 75 || v > 175) e = 1'b1;
    else if (m_two && m_t2 == m_t1) e = 1'b1;
    else r = m_two ? (v - m_t1) * 60 / (m_t2 - m_t1) + 25 : v - m_t1 + 25;
  endfunction

  task automatic load(input logic [31:0] w, input string req);
    @(negedge clk);
    trim_load = 1'b1; trim_word = w;
    @(posedge clk);
    apply(w);
    @(negedge clk);
    trim_load = 1'b0;
    chk({req, " sensor_id"}, int'(sensor_id), int'(w[19:16]));
  endtask

  task automatic conv(input bit ch, input int v, input bit ld, input logic [31:0] w, input string req);
    bit e; int r; int n = 0;
    @(negedge clk);
    while (!(ch ? c2t_ready : t2c_ready)) @(negedge clk);
    model(ch, v, e, r);
    if (ch) begin c2t_valid = 1'b1; c2t_code = 8'(v); end
    else begin t2c_valid = 1'b1; t2c_temp = 8'(v); end
    if (ld) begin trim_load = 1'b1; trim_word = w; end
    @(posedge clk);
    if (ld) apply(w);
    @(negedge clk);
    t2c_valid = 1'b0; c2t_valid = 1'b0; trim_load = 1'b0;
    n = 1;
    while (!(ch ? c2t_done : t2c_done) && n < 40) begin @(negedge clk); n++; end
    chk({req, " R10 latency ok"}, int'(n <= 18), 1);
    chk({req, " err"}, int'(err), int'(e));
    if (!e) chk({req, " result"}, int'(result), r);
  endtask

  initial begin
    bit e1, e2; int r1, r2; bit got1, early;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 t2c_ready", int'(t2c_ready), 1);
    chk("R1 c2t_ready", int'(c2t_ready), 1);
    chk("R1 done low", int'(t2c_done | c2t_done), 0);
    chk("R1 sensor_id", int'(sensor_id), 0);
    conv(1'b1, 100, 1'b0, '0, "R1 default trim1");
    conv(1'b0, 85, 1'b0, '0, "R1 default one-point");

    load(mk(0, 3, 90, 0), "R2 zero");     conv(1, 100, 0, '0, "R2 trim1=0");
    load(mk(0, 5, 90, 39), "R2 low");     conv(1, 100, 0, '0, "R2 trim1=39");
    load(mk(0, 6, 90, 40), "R2 min");     conv(1, 100, 0, '0, "R2 trim1=40");
    load(mk(0, 7, 90, 100), "R2 max");    conv(1, 100, 0, '0, "R2 trim1=100");
    load(mk(0, 8, 90, 101), "R2 high");   conv(1, 100, 0, '0, "R2 trim1=101");
    load(mk(1, 10, 0, 50), "R3 R4");      conv(0, 85, 0, '0, "R3 trim2=0 default");
    load(mk(0, 2, 80, 60), "R5 R6");
    conv(0, 30, 0, '0, "R5 one-point t2c");
    conv(0, 0, 0, '0, "R5 one-point t2c low");
    conv(1, 120, 0, '0, "R6 one-point c2t");
    load(mk(1, 15, 100, 60), "R4 R7");
    conv(0, 20, 0, '0, "R7 t2c trunc neg");
    conv(1, 76, 0, '0, "R7 c2t");
    load(mk(1, 1, 130, 90), "R7 b");
    conv(1, 81, 0, '0, "R7 c2t trunc neg");
    conv(1, 74, 0, '0, "R8 code 74");
    conv(1, 75, 0, '0, "R8 code 75");
    conv(1, 175, 0, '0, "R8 code 175");
    conv(1, 176, 0, '0, "R8 code 176");
    load(mk(1, 9, 70, 70), "R9");
    conv(1, 100, 0, '0, "R9 zero divisor");
    conv(0, 50, 0, '0, "R9 t2c no error");

    load(mk(1, 4, 110, 45), "R11");
    @(negedge clk);
    model(0, 140, e1, r1); model(1, 150, e2, r2);
    t2c_valid = 1'b1; t2c_temp = 8'd140; c2t_valid = 1'b1; c2t_code = 8'd150;
    @(posedge clk);
    @(negedge clk);
    t2c_valid = 1'b0;
    got1 = 1'b0; early = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (t2c_done) begin got1 = 1'b1; chk("R11 t2c first result", int'(result), r1); end
      if (c2t_ready && !got1) early = 1'b1;
      if (c2t_ready) break;
      @(negedge clk);
    end
    chk("R11 t2c served first", int'(got1), 1);
    chk("R11 c2t held off", int'(early), 0);
    @(posedge clk);
    @(negedge clk);
    c2t_valid = 1'b0;
    for (int k = 0; k < 40 && !c2t_done; k++) @(negedge clk);
    chk("R11 c2t after", int'(c2t_done), 1);
    chk("R11 c2t result", int'(result), r2);

    load(mk(1, 4, 110, 45), "R12");
    conv(0, 100, 1, mk(0, 12, 99, 70), "R12 load at accept");
    conv(0, 100, 0, '0, "R12 new trims");

    for (int i = 0; i < 40; i++) begin
      load(mk($urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255)), "R4 rand");
      conv(0, $urandom_range(0, 150), 0, '0, "R7 rand t2c");
      conv(1, $urandom_range(60, 190), 0, '0, "R7 rand c2t");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog got=%0d exp=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule